// File: doc/BRIEF.md
# Weighted Two-Model State Combiner

This block forms one combined state estimate from two model estimates of different lengths. The first model supplies a six-element state vector (positions and velocities). The second model supplies a nine-element vector (positions, velocities and accelerations). Each vector is scaled by its model probability, and the scaled vectors are summed element by element. The first model has no acceleration terms, so the last three output elements come from the second model alone.

Words arrive one per clock on two independent streams, each with its own enable: fifteen state words and two probability words. The block stores them locally. When a frame is complete, it issues one operand pair per clock to two pipelined multipliers. A single pipelined adder then combines the two products. For the acceleration elements, the lone product skips the adder and passes through a matching register delay, so the nine results leave as one unbroken run with an output enable.

State values are signed Q16.16 and probabilities are unsigned Q0.16. Products are rounded and saturated. Sums saturate.

Top module: `tsc_combiner`

## Requirements
- R1: Output elements 0 to 5 equal the saturated sum of round(stateA[i]·probA) and round(stateB[i]·probB).
- R2: Output elements 6 to 8 equal round(stateB[i]·probB) alone, with no contribution from the first model.
- R3: State words are taken in arrival order. The first six fill stateA[0..5] and the next nine fill stateB[0..8]. Probability words are also taken in arrival order: the first is probA and the second is probB. The two streams may interleave or arrive in the same cycle.
- R4: outValid first rises 12 clocks after the edge that captures the final word of a frame. It then stays high for exactly 9 consecutive clocks, carrying elements 0 to 8 in ascending order.
- R5: No result is produced until all 15 state words and both probability words have arrived. outValid stays low while either stream is incomplete.
- R6: A word offered on a stream whose count is already met is ignored. This covers every edge up to and including the ninth edge after the frame completes, while the frame's operands are being issued.
- R7: Each product of a Q16.16 state and a Q0.16 probability is rounded to nearest, with halves rounded up (add 2^15, then drop 16 fraction bits). The result is saturated to the signed 32-bit range.
- R8: The sum for elements 0 to 5 saturates to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R9: A synchronous reset clears stored words, stream counts, pipeline contents and outValid. A partly received frame is discarded, and results in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stateEn | input | 1 | State word strobe |
| stateIn | input | DATA_W | State word, signed Q16.16 |
| probEn | input | 1 | Probability word strobe |
| probIn | input | PROB_W | Probability word, unsigned Q0.16 |
| outValid | output | 1 | Combined element valid |
| outWord | output | DATA_W | Combined element, signed Q16.16 |

## Verification
On every cycle, the assertions check the following:
- Operand issue runs as an unbroken ascending sequence.
- The stream counts stay frozen while a frame is issued.
- The product and sum stages keep the sign their operands demand, so saturation never wraps.
- outValid is low on the first cycle after a reset.

The values themselves, the 12-clock latency, the 9-word run length, the input orderings, the ignoring of surplus words and the discarding of a partial frame are shown only by the bench scenarios. These scenarios compare each output word against products and sums computed arithmetically.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Lengths of the two model state vectors; the shorter one is the prefix.
  localparam int A_LEN   = 6;
  localparam int B_LEN   = 9;
  localparam int STATE_N = A_LEN + B_LEN;
  localparam int PROB_N  = 2;
  localparam int IDX_W   = $clog2(STATE_N + 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic             stateWe;
    logic [IDX_W-1:0] stateAddr;
    logic             probWe;
    logic             probSel;
    logic             issue;
    logic [IDX_W-1:0] issueIdx;
    logic             pairTerm;
  } ctrlStrobe_t;

endpackage

// File: rtl/tsc_delay.sv
module tsc_delay #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [WIDTH-1:0] pipe [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= din;
          for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign dout = pipe[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/tsc_mul.sv
module tsc_mul #(
  parameter int DATA_W = 32,
  parameter int PROB_W = 16,
  parameter int LAT    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] stateOp,
  input  logic        [PROB_W-1:0] probOp,
  output logic signed [DATA_W-1:0] prodOut
);

  localparam int RAW_W = DATA_W + PROB_W + 1;
  localparam int TAIL  = LAT - 2;
  localparam logic signed [RAW_W-1:0] HALF = RAW_W'(1) << (PROB_W - 1);
  localparam logic signed [RAW_W-1:0] MAXV =
    {{(RAW_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [RAW_W-1:0] MINV =
    {{(RAW_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [RAW_W-1:0]  rawQ;
  logic signed [RAW_W-1:0]  rndWide;
  logic signed [DATA_W-1:0] rndSat;
  logic signed [DATA_W-1:0] rndQ;
  logic        [DATA_W-1:0] tailOut;

  // Stage 1: full-width product, probability treated as non-negative.
  always_ff @(posedge clk) begin
    if (rst) rawQ <= '0;
    else     rawQ <= RAW_W'(stateOp) * $signed({{(RAW_W-PROB_W){1'b0}}, probOp});
  end

  // Round half up, drop the probability fraction, clamp to DATA_W.
  always_comb begin
    rndWide = (rawQ + HALF) >>> PROB_W;
    if (rndWide > MAXV)      rndSat = MAXV[DATA_W-1:0];
    else if (rndWide < MINV) rndSat = MINV[DATA_W-1:0];
    else                     rndSat = rndWide[DATA_W-1:0];
  end

  // Stage 2: rounded result.
  always_ff @(posedge clk) begin
    if (rst) rndQ <= '0;
    else     rndQ <= rndSat;
  end

  tsc_delay #(.WIDTH(DATA_W), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .din (rndQ),
    .dout(tailOut)
  );

  assign prodOut = $signed(tailOut);

  // R7
  rnd_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (rawQ >= 0) |=> (rndQ >= 0));

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        stateEn,
  input  logic        probEn,
  output ctrlStrobe_t strb
);

  localparam logic [IDX_W-1:0] STATE_FULL = IDX_W'(STATE_N);
  localparam logic [1:0]       PROB_FULL  = 2'(PROB_N);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(B_LEN - 1);
  localparam logic [IDX_W-1:0] PAIR_END   = IDX_W'(A_LEN);

  logic [IDX_W-1:0] stateCnt;
  logic [1:0]       probCnt;
  logic [IDX_W-1:0] issueIdx;
  logic             frameFull;
  logic             lastIssue;
  logic             stateTake;
  logic             probTake;

  assign frameFull = (stateCnt == STATE_FULL) && (probCnt == PROB_FULL);
  assign lastIssue = frameFull && (issueIdx == LAST_IDX);
  assign stateTake = stateEn && (stateCnt != STATE_FULL);
  assign probTake  = probEn && (probCnt != PROB_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateCnt <= '0;
      probCnt  <= '0;
      issueIdx <= '0;
    end else if (lastIssue) begin
      stateCnt <= '0;
      probCnt  <= '0;
      issueIdx <= '0;
    end else begin
      if (stateTake) stateCnt <= stateCnt + 1'b1;
      if (probTake)  probCnt  <= probCnt + 1'b1;
      if (frameFull) issueIdx <= issueIdx + 1'b1;
    end
  end

  always_comb begin
    strb.stateWe   = stateTake;
    strb.stateAddr = stateCnt;
    strb.probWe    = probTake;
    strb.probSel   = probCnt[0];
    strb.issue     = frameFull;
    strb.issueIdx  = issueIdx;
    strb.pairTerm  = issueIdx < PAIR_END;
  end

  // R4
  issue_run_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && !lastIssue) |=> (strb.issue && (strb.issueIdx == $past(strb.issueIdx) + 1'b1)));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.issue && !lastIssue) |=> ($stable(stateCnt) && $stable(probCnt)));

endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PROB_W  = 16,
  parameter int MUL_LAT = 5,
  parameter int ADD_LAT = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobe_t              strb,
  input  logic signed [DATA_W-1:0] stateIn,
  input  logic        [PROB_W-1:0] probIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outWord
);

  localparam int TAG_LAT = MUL_LAT + ADD_LAT;
  localparam logic [IDX_W-1:0] B_BASE = IDX_W'(A_LEN);
  localparam logic signed [DATA_W-1:0] SUM_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SUM_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] stateMem [STATE_N];
  logic        [PROB_W-1:0] probMem  [PROB_N];

  logic signed [DATA_W-1:0] opA;
  logic signed [DATA_W-1:0] opB;
  logic signed [DATA_W-1:0] prodA;
  logic signed [DATA_W-1:0] prodB;
  logic signed [DATA_W:0]   sumWide;
  logic signed [DATA_W-1:0] sumSat;
  logic signed [DATA_W-1:0] sumQ;
  logic        [DATA_W-1:0] sumOut;
  logic        [DATA_W-1:0] bypassOut;
  logic        [1:0]        tagIn;
  logic        [1:0]        tagOut;

  // Local storage written under control strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STATE_N; i++) stateMem[i] <= '0;
      for (int i = 0; i < PROB_N; i++)  probMem[i]  <= '0;
    end else begin
      if (strb.stateWe) stateMem[strb.stateAddr] <= stateIn;
      if (strb.probWe)  probMem[strb.probSel]    <= probIn;
    end
  end

  // Operand distribution; the short model contributes zero past its length.
  assign opA = strb.pairTerm ? stateMem[strb.issueIdx] : '0;
  assign opB = stateMem[B_BASE + strb.issueIdx];

  tsc_mul #(.DATA_W(DATA_W), .PROB_W(PROB_W), .LAT(MUL_LAT)) u_mulA (
    .clk    (clk),
    .rst    (rst),
    .stateOp(opA),
    .probOp (probMem[0]),
    .prodOut(prodA)
  );

  tsc_mul #(.DATA_W(DATA_W), .PROB_W(PROB_W), .LAT(MUL_LAT)) u_mulB (
    .clk    (clk),
    .rst    (rst),
    .stateOp(opB),
    .probOp (probMem[1]),
    .prodOut(prodB)
  );

  // Saturating adder: first stage sums, remaining stages delay.
  always_comb begin
    sumWide = $signed({prodA[DATA_W-1], prodA}) + $signed({prodB[DATA_W-1], prodB});
    if (sumWide[DATA_W] != sumWide[DATA_W-1])
      sumSat = sumWide[DATA_W] ? SUM_MIN : SUM_MAX;
    else
      sumSat = sumWide[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) sumQ <= '0;
    else     sumQ <= sumSat;
  end

  tsc_delay #(.WIDTH(DATA_W), .DEPTH(ADD_LAT - 1)) u_addTail (
    .clk (clk),
    .rst (rst),
    .din (sumQ),
    .dout(sumOut)
  );

  // Lone products bypass the adder through an equal-latency delay.
  tsc_delay #(.WIDTH(DATA_W), .DEPTH(ADD_LAT)) u_bypass (
    .clk (clk),
    .rst (rst),
    .din (prodB),
    .dout(bypassOut)
  );

  assign tagIn = {strb.issue, strb.pairTerm};

  tsc_delay #(.WIDTH(2), .DEPTH(TAG_LAT)) u_tag (
    .clk (clk),
    .rst (rst),
    .din (tagIn),
    .dout(tagOut)
  );

  assign outValid = tagOut[1];
  assign outWord  = tagOut[0] ? $signed(sumOut) : $signed(bypassOut);

  // R8
  sum_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (!prodA[DATA_W-1] && !prodB[DATA_W-1]) |=> !sumQ[DATA_W-1]);

  // R8
  sum_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (prodA[DATA_W-1] && prodB[DATA_W-1]) |=> sumQ[DATA_W-1]);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

endmodule

// File: rtl/tsc_combiner.sv
module tsc_combiner
  import tsc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PROB_W  = 16,
  parameter int MUL_LAT = 5,
  parameter int ADD_LAT = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stateEn,
  input  logic signed [DATA_W-1:0] stateIn,
  input  logic                     probEn,
  input  logic        [PROB_W-1:0] probIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outWord
);

  ctrlStrobe_t strb;

  tsc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stateEn(stateEn),
    .probEn (probEn),
    .strb   (strb)
  );

  tsc_datapath #(
    .DATA_W (DATA_W),
    .PROB_W (PROB_W),
    .MUL_LAT(MUL_LAT),
    .ADD_LAT(ADD_LAT)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .stateIn (stateIn),
    .probIn  (probIn),
    .outValid(outValid),
    .outWord (outWord)
  );

endmodule

// File: tb/test_tsc_combiner.sv
`timescale 1ns/1ps
module test_tsc_combiner;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               stateEn = 1'b0;
  logic signed [31:0] stateIn = '0;
  logic               probEn = 1'b0;
  logic        [15:0] probIn = '0;
  logic               outValid;
  logic signed [31:0] outWord;

  int checks = 0;
  int fails  = 0;

  logic signed [31:0] sA [6];
  logic signed [31:0] sB [9];
  logic        [15:0] pA, pB;

  always #2.5 clk = ~clk;

  tsc_combiner i_tsc_combiner (
    .clk(clk), .rst(rst), .stateEn(stateEn), .stateIn(stateIn),
    .probEn(probEn), .probIn(probIn), .outValid(outValid), .outWord(outWord)
  );

  function automatic logic [31:0] satq(longint v);
    if (v > 64'sh7FFFFFFF) return 32'h7FFFFFFF;
    if (v < -64'sh80000000) return 32'h80000000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] prodq(logic signed [31:0] s, logic [15:0] p);
    longint t;
    t = longint'(s) * longint'(p);
    t = (t + 32768) >>> 16;
    return satq(t);
  endfunction

  function automatic logic [31:0] expOut(int k);
    if (k < 6)
      return satq(longint'($signed(prodq(sA[k], pA))) + longint'($signed(prodq(sB[k], pB))));
    return prodq(sB[k], pB);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setData(int f);
    for (int i = 0; i < 6; i++) sA[i] = 32'(f * 19088743 + i * 252645719) ^ 32'(i << 21);
    for (int i = 0; i < 9; i++) sB[i] = 32'(f * 40503 - i * 123456789) ^ 32'(f << 9);
  endtask

  // R3: order 0 = probabilities first, 1 = states first, 2 = interleaved.
  task automatic driveFrame(int order);
    int lastC;
    lastC = (order == 2) ? 14 : 16;
    for (int c = 0; c <= lastC; c++) begin
      int sIdx, pIdx;
      @(negedge clk);
      sIdx = -1; pIdx = -1;
      case (order)
        0: begin pIdx = (c < 2) ? c : -1; sIdx = (c >= 2) ? c - 2 : -1; end
        1: begin sIdx = (c < 15) ? c : -1; pIdx = (c >= 15) ? c - 15 : -1; end
        default: begin sIdx = c; pIdx = (c == 0) ? 0 : ((c == 14) ? 1 : -1); end
      endcase
      stateEn = (sIdx >= 0);
      stateIn = (sIdx < 0) ? 32'h0 : ((sIdx < 6) ? sA[sIdx] : sB[sIdx - 6]);
      probEn  = (pIdx >= 0);
      probIn  = (pIdx == 1) ? pB : ((pIdx == 0) ? pA : 16'h0);
    end
  endtask

  // Called right after the final word was driven; checks timing and values.
  task automatic collect(bit extras);
    bit early;
    early = 1'b0;
    @(negedge clk);
    stateEn = extras; stateIn = 32'h7FFF0000;
    probEn  = extras; probIn  = 16'hFFFF;
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      if (i == 3) begin stateEn = 1'b0; probEn = 1'b0; end
      early |= outValid;
    end
    // R4: nothing valid before the twelfth clock
    check(!early, "R4 early valid", 32'(early), 32'h0);
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      logic [31:0] e;
      e = expOut(k);
      if (k < 6) check(outValid === 1'b1 && outWord === e, "R1 paired element", outWord, e);
      else       check(outValid === 1'b1 && outWord === e, "R2 lone element", outWord, e);
      @(negedge clk);
    end
    // R4: run ends after nine words
    check(outValid === 1'b0, "R4 run length", 32'(outValid), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] plist [5];
    bit early;
    plist[0] = 16'h0000; plist[1] = 16'h0001; plist[2] = 16'h8000;
    plist[3] = 16'hFFFF; plist[4] = 16'h2AAB;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet after reset
    check(outValid === 1'b0, "R9 reset state", 32'(outValid), 32'h0);

    // Sweep of probability pairs across input orderings; R6 surplus words.
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        int f;
        f = a * 5 + b;
        setData(f);
        pA = plist[a]; pB = plist[b];
        driveFrame(f % 3);
        collect(f % 4 == 1); // R6 surplus words during issue
      end
    end

    // R8: saturation both ways
    setData(99);
    pA = 16'hFFFF; pB = 16'hFFFF;
    sA[0] = 32'h7FFFFFFF; sB[0] = 32'h7FFFFFFF;
    sA[1] = 32'h80000000; sB[1] = 32'h80000000;
    check(expOut(0) == 32'h7FFFFFFF && expOut(1) == 32'h80000000, "R8 model", expOut(0), 32'h7FFFFFFF);
    driveFrame(1);
    collect(1'b0);

    // R7: round half up on exact halves
    setData(7);
    pA = 16'h8000; pB = 16'h8000;
    sB[6] = 32'sd1; sB[7] = -32'sd1; sB[8] = 32'sd3;
    check(expOut(6) == 32'd1 && expOut(7) == 32'd0 && expOut(8) == 32'd2, "R7 model", expOut(6), 32'd1);
    driveFrame(0);
    collect(1'b1);

    // R5: one probability missing holds everything back
    setData(55);
    pA = 16'h4000; pB = 16'h3000;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      stateEn = 1'b1; stateIn = (c < 6) ? sA[c] : sB[c - 6];
      probEn = (c == 0); probIn = pA;
    end
    @(negedge clk);
    stateEn = 1'b0; probEn = 1'b0;
    early = 1'b0;
    repeat (30) begin @(negedge clk); early |= outValid; end
    check(!early, "R5 premature start", 32'(early), 32'h0);
    probEn = 1'b1; probIn = pB;
    collect(1'b0);

    // R9: partial frame discarded by reset
    setData(200);
    pA = 16'hFFFF; pB = 16'h0101;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      stateEn = 1'b1; stateIn = 32'h5A5A5A5A; probEn = (c == 2); probIn = 16'h1111;
    end
    @(negedge clk);
    stateEn = 1'b0; probEn = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    driveFrame(2);
    collect(1'b0);

    // R9: results in flight dropped by reset
    setData(300);
    driveFrame(1);
    @(negedge clk);
    stateEn = 1'b0; probEn = 1'b0;
    repeat (13) @(negedge clk);
    check(outValid === 1'b1, "R9 stream started", 32'(outValid), 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    early = 1'b0;
    repeat (15) begin @(negedge clk); early |= outValid; end
    check(!early, "R9 in-flight dropped", 32'(early), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule